// File: doc/BRIEF.md
# Address Guard and Relocation Unit

The unit sits on the path from a processor's address output to memory. For each request it either forwards an address to memory or raises a trap. Trusted (kernel) software chooses one of three protection schemes through a 2-bit mode register:

- **Fence** keeps user accesses out of the low kernel region.
- **Window** confines user accesses to an open interval between two limits. The address is not changed.
- **Relocate** checks the address against a length and adds a base to it. Because the base can be reloaded, a process that was moved out of memory can come back at a different place.

Kernel software loads the mode, fence, window and relocation values through a small write port. This port is only honoured while the kernel-mode input is high. Kernel-mode requests bypass all checks.

The window limits are held by a two-state controller:

| State | Meaning |
|-------|---------|
| `WIN_OPEN` | The window limits may be written. |
| `WIN_SEALED` | The window limits are frozen. |

Its transitions are:

- **seal**: `WIN_OPEN` to `WIN_SEALED`, taken on a kernel write of the upper limit.
- **release**: `WIN_SEALED` to `WIN_OPEN`, taken on a kernel write of the release code.
- **hold**: stay in the current state otherwise.

This way the window stays fixed for the life of a process once it has been loaded. Every result is registered and appears one clock after the request.

Top module: `addr_guard_unit`

## Requirements
- R1: Fence mode (mode code 0). A user request whose address is at or below the fence value traps. A user request above the fence goes to memory with the address unchanged.
- R2: Window mode (mode code 1). A user request passes with its address unchanged only when lower < address < upper. Any other user request traps.
- R3: Relocate mode (mode code 2). A user request with address < length goes to memory at (base + address) modulo 2^AW. A user request with address >= length traps.
- R4: Mode code 3 traps every user request.
- R5: Timing of the outputs:
  - `mem_valid`, `mem_addr` and `trap` are registered and appear one cycle after `cpu_valid`.
  - `trap` is a single-cycle pulse for each trapping request.
  - `mem_valid` is low whenever `trap` is high.
  - Both outputs are low in the cycle after a cycle with no request.
- R6: A request made with `kern_mode` high goes to memory with its address unchanged and never traps, whatever the mode.
- R7: Register writes and their select codes:
  - `cfg_sel` codes: 0 = mode (data bits 1:0), 1 = fence, 2 = lower, 3 = upper, 4 = base, 5 = length, 6 = release.
  - A write takes effect for requests from the next cycle on.
  - A write made while `kern_mode` is low is ignored.
- R8: Window sealing:
  - Writing the upper limit seals the window.
  - While sealed, writes to the lower or upper limit are ignored until a release write.
  - Base and length can always be rewritten.
- R9: After reset:
  - The mode is fence.
  - Every value register is 0.
  - The window is open.
  - `mem_valid` and `trap` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kern_mode | input | 1 | Privileged mode; enables writes and bypasses checking |
| cpu_valid | input | 1 | Request strobe |
| cpu_addr | input | AW | Address from the processor |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | AW | Register write data |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_addr | output | AW | Address sent to memory |
| trap | output | 1 | Protection violation pulse |

## Verification
The bench probes addresses exactly at and next to each limit:

- **Fence, window and length edges.** A design that flipped `<` and `<=` at any of these would let an edge address through, or trap a legal one.
- **Relocation wrap-around.** A base close to the top of the space must wrap modulo 2^AW.
- **Base reload.** Reloading the base must move the target region at once.
- **Stray writes.** Writes made in user mode, and window writes made while sealed, must leave the next request's result unchanged. A design that honoured them would change which addresses trap.
- **Kernel bypass in the trapping mode.** A kernel request in mode 3 must pass.
- **Single-cycle trap.** A design that stretched the trap pulse would show it in the idle cycle after the trap.

// File: rtl/addr_guard_pkg.sv
package addr_guard_pkg;

    typedef enum logic [1:0] {
        MODE_FENCE    = 2'd0,
        MODE_WINDOW   = 2'd1,
        MODE_RELOCATE = 2'd2,
        MODE_BLOCKED  = 2'd3
    } guard_mode_e;

    typedef enum logic [2:0] {
        SEL_MODE    = 3'd0,
        SEL_FENCE   = 3'd1,
        SEL_LOWER   = 3'd2,
        SEL_UPPER   = 3'd3,
        SEL_BASE    = 3'd4,
        SEL_LENGTH  = 3'd5,
        SEL_RELEASE = 3'd6,
        SEL_SPARE   = 3'd7
    } cfg_sel_e;

    typedef enum logic {
        WIN_OPEN   = 1'b0,
        WIN_SEALED = 1'b1
    } win_state_e;

endpackage

// File: rtl/guard_cfg_regs.sv
module guard_cfg_regs
    import addr_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kern_mode,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output guard_mode_e   mode_q,
    output logic [AW-1:0] fence_q,
    output logic [AW-1:0] lower_q,
    output logic [AW-1:0] upper_q,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] length_q,
    output win_state_e    win_state
);

    win_state_e win_next;
    logic       wr_ok;
    cfg_sel_e   sel;

    assign wr_ok = cfg_we && kern_mode;
    assign sel   = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_state <= WIN_OPEN;
        end else begin
            win_state <= win_next;
        end
    end

    always_comb begin
        win_next = win_state;
        unique case (win_state)
            WIN_OPEN:   if (wr_ok && sel == SEL_UPPER)   win_next = WIN_SEALED;
            WIN_SEALED: if (wr_ok && sel == SEL_RELEASE) win_next = WIN_OPEN;
            default:    win_next = WIN_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_FENCE;
            fence_q  <= '0;
            lower_q  <= '0;
            upper_q  <= '0;
            base_q   <= '0;
            length_q <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_MODE:   mode_q   <= guard_mode_e'(cfg_wdata[1:0]);
                SEL_FENCE:  fence_q  <= cfg_wdata;
                SEL_LOWER:  if (win_state == WIN_OPEN) lower_q <= cfg_wdata;
                SEL_UPPER:  if (win_state == WIN_OPEN) upper_q <= cfg_wdata;
                SEL_BASE:   base_q   <= cfg_wdata;
                SEL_LENGTH: length_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // R7: nothing changes without kernel mode
    p_user_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !kern_mode |=> $stable(fence_q) && $stable(base_q) && $stable(length_q)
                       && $stable(mode_q) && $stable(lower_q) && $stable(upper_q));

    // R8: sealed window limits hold unless released
    p_sealed_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_state == WIN_SEALED) |=> $stable(lower_q) && $stable(upper_q));

endmodule

// File: rtl/guard_check.sv
module guard_check
    import addr_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  guard_mode_e   mode,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] fence,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] upper,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] length,
    output logic          fail,
    output logic [AW-1:0] xlat_addr
);

    always_comb begin
        fail      = 1'b0;
        xlat_addr = addr;
        unique case (mode)
            MODE_FENCE:    fail = (addr <= fence);
            MODE_WINDOW:   fail = !((addr > lower) && (addr < upper));
            MODE_RELOCATE: begin
                fail      = (addr >= length);
                xlat_addr = base + addr;
            end
            MODE_BLOCKED:  fail = 1'b1;
            default:       fail = 1'b1;
        endcase
    end

endmodule

// File: rtl/addr_guard_unit.sv
module addr_guard_unit
    import addr_guard_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          kern_mode,
    input  logic          cpu_valid,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic          trap
);

    guard_mode_e   mode_q;
    win_state_e    win_state;
    logic [AW-1:0] fence_q, lower_q, upper_q, base_q, length_q;
    logic          fail;
    logic [AW-1:0] xlat_addr;

    guard_cfg_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .kern_mode (kern_mode),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .mode_q    (mode_q),
        .fence_q   (fence_q),
        .lower_q   (lower_q),
        .upper_q   (upper_q),
        .base_q    (base_q),
        .length_q  (length_q),
        .win_state (win_state)
    );

    guard_check #(.AW(AW)) u_check (
        .mode      (mode_q),
        .addr      (cpu_addr),
        .fence     (fence_q),
        .lower     (lower_q),
        .upper     (upper_q),
        .base      (base_q),
        .length    (length_q),
        .fail      (fail),
        .xlat_addr (xlat_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_valid <= 1'b0;
            mem_addr  <= '0;
            trap      <= 1'b0;
        end else begin
            mem_valid <= cpu_valid && (kern_mode || !fail);
            trap      <= cpu_valid && !kern_mode && fail;
            mem_addr  <= kern_mode ? cpu_addr : xlat_addr;
        end
    end

    // R5: a trap never coexists with a forwarded request
    p_trap_blocks_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && mem_valid));

    // R5: outputs only follow an actual request
    p_no_request_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_valid |=> !mem_valid && !trap);

    // R6: kernel requests bypass translation and checks
    p_kernel_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && kern_mode) |=> mem_valid && !trap && (mem_addr == $past(cpu_addr)));

    // R4: the blocked mode never forwards a user request
    p_blocked_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !kern_mode && mode_q == MODE_BLOCKED) |=> trap);

endmodule

// File: tb/tb_addr_guard_unit.sv
`timescale 1ns/1ps
module tb_addr_guard_unit;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          kern_mode;
    logic          cpu_valid;
    logic [AW-1:0] cpu_addr;
    logic          cfg_we;
    logic [2:0]    cfg_sel;
    logic [AW-1:0] cfg_wdata;
    logic          mem_valid;
    logic [AW-1:0] mem_addr;
    logic          trap;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_guard_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .kern_mode(kern_mode), .cpu_valid(cpu_valid),
        .cpu_addr(cpu_addr), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .trap(trap)
    );

    task automatic chk(input string req, input logic ev, input logic et,
                       input logic [AW-1:0] ea, input logic cmp_addr);
        checks++;
        if (mem_valid !== ev || trap !== et || (cmp_addr && mem_addr !== ea)) begin
            errors++;
            $display("FAIL %s: valid=%0b trap=%0b addr=%h, expected valid=%0b trap=%0b addr=%h",
                     req, mem_valid, trap, mem_addr, ev, et, ea);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [AW-1:0] data, input logic kern);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data; kern_mode = kern;
        @(negedge clk);
        cfg_we = 1'b0; kern_mode = 1'b0;
    endtask

    task automatic req(input string tag, input logic [AW-1:0] a, input logic kern,
                       input logic ev, input logic et, input logic [AW-1:0] ea);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_addr = a; kern_mode = kern;
        @(negedge clk);
        cpu_valid = 1'b0; kern_mode = 1'b0;
        chk(tag, ev, et, ea, ev);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9 reset outputs", 1'b0, 1'b0, '0, 1'b0);
        req("R9 reset fence=0 traps addr 0", 16'h0000, 1'b0, 1'b0, 1'b1, '0);
        req("R9 reset fence mode passes addr 1", 16'h0001, 1'b0, 1'b1, 1'b0, 16'h0001);
    endtask

    task automatic t_fence;
        wr(3'd0, 16'd0, 1'b1);
        wr(3'd1, 16'h1000, 1'b1);
        req("R1 at fence", 16'h1000, 1'b0, 1'b0, 1'b1, '0);
        req("R1 above fence", 16'h1001, 1'b0, 1'b1, 1'b0, 16'h1001);
        req("R1 below fence", 16'h0FFF, 1'b0, 1'b0, 1'b1, '0);
        @(negedge clk);
        chk("R5 trap lasts one cycle", 1'b0, 1'b0, '0, 1'b0);
        wr(3'd1, 16'h0000, 1'b0);
        req("R7 user write to fence ignored", 16'h0FFF, 1'b0, 1'b0, 1'b1, '0);
    endtask

    task automatic t_window;
        wr(3'd0, 16'd1, 1'b1);
        wr(3'd2, 16'h2000, 1'b1);
        wr(3'd3, 16'h3000, 1'b1);
        req("R2 at lower", 16'h2000, 1'b0, 1'b0, 1'b1, '0);
        req("R2 just above lower", 16'h2001, 1'b0, 1'b1, 1'b0, 16'h2001);
        req("R2 just below upper", 16'h2FFF, 1'b0, 1'b1, 1'b0, 16'h2FFF);
        req("R2 at upper", 16'h3000, 1'b0, 1'b0, 1'b1, '0);
        wr(3'd2, 16'h0000, 1'b1);
        req("R8 sealed lower write ignored", 16'h1000, 1'b0, 1'b0, 1'b1, '0);
        wr(3'd6, 16'h0000, 1'b1);
        wr(3'd2, 16'h0800, 1'b1);
        req("R8 lower accepted after release", 16'h1000, 1'b0, 1'b1, 1'b0, 16'h1000);
    endtask

    task automatic t_relocate;
        wr(3'd0, 16'd2, 1'b1);
        wr(3'd4, 16'h8000, 1'b1);
        wr(3'd5, 16'h0100, 1'b1);
        req("R3 last legal offset", 16'h00FF, 1'b0, 1'b1, 1'b0, 16'h80FF);
        req("R3 at length", 16'h0100, 1'b0, 1'b0, 1'b1, '0);
        wr(3'd4, 16'h9000, 1'b1);
        req("R3 R8 base reload moves region", 16'h0010, 1'b0, 1'b1, 1'b0, 16'h9010);
        wr(3'd4, 16'hFFF0, 1'b1);
        req("R3 wrap modulo 2^AW", 16'h0020, 1'b0, 1'b1, 1'b0, 16'h0010);
        wr(3'd0, 16'd0, 1'b0);
        req("R7 user mode write ignored", 16'h0001, 1'b0, 1'b1, 1'b0, 16'hFFF1);
    endtask

    task automatic t_blocked_kernel;
        wr(3'd0, 16'd3, 1'b1);
        req("R4 mode 3 traps user", 16'h4000, 1'b0, 1'b0, 1'b1, '0);
        req("R6 kernel bypass in mode 3", 16'h1234, 1'b1, 1'b1, 1'b0, 16'h1234);
        wr(3'd0, 16'd2, 1'b1);
        req("R6 kernel not relocated", 16'h0500, 1'b1, 1'b1, 1'b0, 16'h0500);
    endtask

    initial begin
        rst_n = 1'b0; kern_mode = 1'b0; cpu_valid = 1'b0; cpu_addr = '0;
        cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fence();
        t_window();
        t_relocate();
        t_blocked_kernel();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule